// File: doc/BRIEF.md
# SDRAM Command Interval Guard

This block keeps one 16-bit timing configuration word that software writes over a simple register bus. It turns four 2-bit fields of that word into minimum clock counts. It then uses those counts to decide, cycle by cycle, whether a command asked for by a single-bank SDRAM controller may go out now. The controller presents one request code per cycle: open a row, access the open row, close the row, or nothing. The block answers with a grant in the same cycle once every interval that the request depends on has run out.

Two bits of the word act as a setup key and must hold the pattern 01 before any command is granted. They reset to 00, so a fresh block refuses every command until software writes the key. A field holding an unsupported code raises the error output. The guard then applies the longest supported count for that field, which keeps timing safe. Counts are sampled when a command is granted, so rewriting the word never stretches or shortens an interval that is already running.

Top module: `sdr_timing_guard`

## Requirements
- R1: After reset the stored word is zero, `cfg_rdata` reads 0x0000, `row_open` is 0, `cfg_err` is 1 and no request is granted.
- R2: A cycle with `cfg_sel` and `cfg_we` high stores `cfg_wdata[9:0]`. `cfg_rdata` then shows those ten bits in bits 9:0, and bits 15:10 always read 0.
- R3: While bits 9:8 of the word differ from 01, no request is granted and `cfg_err` is 1.
- R4: Bits 5:4 set the shortest gap between two row opens: code 00 gives 4 cycles, code 01 gives 7 cycles.
- R5: Bits 7:6 set the shortest gap from a row open to a row close: code 00 gives 3 cycles, code 01 gives 5 cycles.
- R6: Bits 3:2 set the shortest gap from a row close to the next row open: code 00 gives 1 cycle, code 10 gives 3 cycles.
- R7: Bits 1:0 set the shortest gap from a row open to an access: code 00 gives 1 cycle, code 01 gives 2 cycles.
- R8: An unsupported code (bits 7:6, 5:4 or 1:0 equal to 10 or 11; bits 3:2 equal to 01 or 11) sets `cfg_err` to 1 and applies that field's longest count (5, 7, 3 or 2 cycles).
- R9: Request codes on `cmd_op` are 00 nothing, 01 open row, 10 access, 11 close row. A grant is combinational in the first cycle in which every gap that applies has run out. A gap of N cycles means the grant comes at least N cycles after the earlier grant.
- R10: An access or a close is never granted while no row is open. An open is never granted while a row is open. Code 00 is never granted. `row_open` goes high after a granted open and low after a granted close.
- R11: A write to the word during a running gap leaves that gap at the length loaded when its command was granted. Commands granted after the write use the new counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_sel | input | 1 | Register address match |
| cfg_we | input | 1 | Write enable, qualified by `cfg_sel` |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Current register contents, bits 15:10 zero |
| cfg_err | output | 1 | Setup key wrong or a field holds an unsupported code |
| cmd_op | input | 2 | Requested command (00 none, 01 open, 10 access, 11 close) |
| cmd_gnt | output | 1 | The requested command may issue in this cycle |
| row_open | output | 1 | A row is currently open |

## Verification
The bench measures the exact grant-to-grant gaps for several legal code mixes. This catches an off-by-one counter, which would grant one cycle early or late. The mixes include one where the close-to-open gap, not the open-to-open gap, sets the distance between opens. Two configurations full of unsupported codes confirm that the longest count is applied. A design that used the raw code, or the short value, would grant too early. The bench also probes the reset key pattern and every out-of-order request. It rewrites the word while an interval is running, so a design that reloaded a counter on the write shows a shorter gap.

// File: rtl/sdr_tg_pkg.sv
package sdr_tg_pkg;

    localparam int REG_W   = 16;
    localparam int KEEP_W  = 10;
    localparam int MAX_CNT = 7;
    localparam int CNT_W   = $clog2(MAX_CNT + 1);

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_OPEN  = 2'b01,
        OP_RW    = 2'b10,
        OP_CLOSE = 2'b11
    } op_e;

    typedef struct packed {
        cnt_t ras;   // open to close
        cnt_t rc;    // open to open
        cnt_t rp;    // close to open
        cnt_t rcd;   // open to access
        logic bad;   // some field unsupported
    } timing_t;

    function automatic timing_t decode(input logic [KEEP_W-1:0] w);
        timing_t t;
        logic b_ras, b_rc, b_rp, b_rcd;
        b_ras = w[7:6] != 2'b00 && w[7:6] != 2'b01;
        b_rc  = w[5:4] != 2'b00 && w[5:4] != 2'b01;
        b_rp  = w[3:2] != 2'b00 && w[3:2] != 2'b10;
        b_rcd = w[1:0] != 2'b00 && w[1:0] != 2'b01;
        t.ras = (w[7:6] == 2'b00) ? cnt_t'(3) : cnt_t'(5);
        t.rc  = (w[5:4] == 2'b00) ? cnt_t'(4) : cnt_t'(7);
        t.rp  = (w[3:2] == 2'b00) ? cnt_t'(1) : cnt_t'(3);
        t.rcd = (w[1:0] == 2'b00) ? cnt_t'(1) : cnt_t'(2);
        t.bad = b_ras | b_rc | b_rp | b_rcd;
        return t;
    endfunction

endpackage

// File: rtl/sdr_tg_regfile.sv
module sdr_tg_regfile
    import sdr_tg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_sel,
    input  logic             cfg_we,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    output logic             cfg_err,
    output logic             key_ok,
    output timing_t          tim
);

    logic [KEEP_W-1:0] word_q;

    always_ff @(posedge clk) begin
        if (rst)
            word_q <= '0;
        else if (cfg_sel && cfg_we)
            word_q <= cfg_wdata[KEEP_W-1:0];
    end

    always_comb begin
        tim       = decode(word_q);
        key_ok    = word_q[9:8] == 2'b01;
        cfg_err   = tim.bad | ~key_ok;
        cfg_rdata = {{(REG_W-KEEP_W){1'b0}}, word_q};
    end

    // R2
    wr_readback_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_sel && cfg_we) |=> (cfg_rdata[KEEP_W-1:0] == $past(cfg_wdata[KEEP_W-1:0])));

    // R2
    rd_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_sel && cfg_we) |=> (cfg_rdata[REG_W-1:KEEP_W] == '0));

endmodule

// File: rtl/sdr_tg_window.sv
module sdr_tg_window
    import sdr_tg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  cnt_t len,
    output logic done
);

    cnt_t cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= len - cnt_t'(1);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - cnt_t'(1);
    end

    assign done = cnt_q == '0;

    // R11
    no_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !done) |=> (cnt_q == $past(cnt_q) - cnt_t'(1)));

endmodule

// File: rtl/sdr_tg_tracker.sv
module sdr_tg_tracker
    import sdr_tg_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    key_ok,
    input  timing_t tim,
    input  op_e     op,
    output logic    gnt,
    output logic    row_open
);

    logic open_q;
    logic ras_done, rc_done, rp_done, rcd_done;
    logic g_open, g_rw, g_close;

    sdr_tg_window u_ras (.clk(clk), .rst(rst), .load(g_open),  .len(tim.ras), .done(ras_done));
    sdr_tg_window u_rc  (.clk(clk), .rst(rst), .load(g_open),  .len(tim.rc),  .done(rc_done));
    sdr_tg_window u_rcd (.clk(clk), .rst(rst), .load(g_open),  .len(tim.rcd), .done(rcd_done));
    sdr_tg_window u_rp  (.clk(clk), .rst(rst), .load(g_close), .len(tim.rp),  .done(rp_done));

    always_comb begin
        g_open  = key_ok && op == OP_OPEN  && !open_q && rc_done && rp_done;
        g_rw    = key_ok && op == OP_RW    &&  open_q && rcd_done;
        g_close = key_ok && op == OP_CLOSE &&  open_q && ras_done;
        gnt     = g_open | g_rw | g_close;
    end

    always_ff @(posedge clk) begin
        if (rst)
            open_q <= 1'b0;
        else if (g_open)
            open_q <= 1'b1;
        else if (g_close)
            open_q <= 1'b0;
    end

    assign row_open = open_q;

    // R3
    key_gate_chk: assert property (@(posedge clk) disable iff (rst)
        gnt |-> key_ok);

    // R10
    close_needs_row_chk: assert property (@(posedge clk) disable iff (rst)
        (gnt && op == OP_CLOSE) |-> row_open);

    // R10
    rw_needs_row_chk: assert property (@(posedge clk) disable iff (rst)
        (gnt && op == OP_RW) |-> row_open);

    // R10
    open_needs_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (gnt && op == OP_OPEN) |-> !row_open);

    // R10
    row_follows_open_chk: assert property (@(posedge clk) disable iff (rst)
        (!row_open && !(gnt && op == OP_OPEN)) |=> !row_open);

endmodule

// File: rtl/sdr_timing_guard.sv
module sdr_timing_guard
    import sdr_tg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_sel,
    input  logic        cfg_we,
    input  logic [15:0] cfg_wdata,
    output logic [15:0] cfg_rdata,
    output logic        cfg_err,
    input  logic [1:0]  cmd_op,
    output logic        cmd_gnt,
    output logic        row_open
);

    timing_t tim;
    logic    key_ok;

    sdr_tg_regfile u_regs (
        .clk(clk), .rst(rst),
        .cfg_sel(cfg_sel), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .cfg_err(cfg_err),
        .key_ok(key_ok), .tim(tim)
    );

    sdr_tg_tracker u_trk (
        .clk(clk), .rst(rst),
        .key_ok(key_ok), .tim(tim), .op(op_e'(cmd_op)),
        .gnt(cmd_gnt), .row_open(row_open)
    );

endmodule

// File: tb/tb_sdr_timing_guard.sv
module tb_sdr_timing_guard;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_sel = 1'b0, cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        cfg_err, cmd_gnt, row_open;
    logic [1:0]  cmd_op = 2'b00;

    int checks = 0, fails = 0, cyc = 0;

    localparam logic [1:0] NOP = 2'b00, OPN = 2'b01, ACC = 2'b10, CLS = 2'b11;

    typedef struct packed {
        logic [15:0] cfg;
        logic [7:0]  rcd;
        logic [7:0]  ras;
        logic [7:0]  o2o;   // open-to-open with close issued as early as allowed
        logic        err;
    } vec_t;

    localparam vec_t TBL [6] = '{
        '{16'h0100, 8'd1, 8'd3, 8'd4, 1'b0},
        '{16'h0159, 8'd2, 8'd5, 8'd8, 1'b0},
        '{16'h0110, 8'd1, 8'd3, 8'd7, 1'b0},
        '{16'h01E7, 8'd2, 8'd5, 8'd8, 1'b1},
        '{16'h0148, 8'd1, 8'd5, 8'd8, 1'b0},
        '{16'h010C, 8'd1, 8'd3, 8'd6, 1'b1}
    };

    sdr_timing_guard dut (
        .clk(clk), .rst(rst), .cfg_sel(cfg_sel), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_err(cfg_err),
        .cmd_op(cmd_op), .cmd_gnt(cmd_gnt), .row_open(row_open)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [15:0] v);
        @(negedge clk); cfg_sel = 1'b1; cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_sel = 1'b0; cfg_we = 1'b0; cfg_wdata = '0;
    endtask

    // drives a request until granted, returns the cycle index of the grant
    task automatic issue(input logic [1:0] op, output int at);
        at = -1;
        @(negedge clk); cmd_op = op;
        for (int i = 0; i < 40; i++) begin
            #1;
            if (cmd_gnt) begin at = cyc; break; end
            @(negedge clk);
        end
        if (at >= 0) begin @(posedge clk); #1; end
        cmd_op = NOP;
    endtask

    // holds a request n cycles, returns how many cycles it was granted
    task automatic probe(input logic [1:0] op, input int n, output int hits);
        hits = 0;
        @(negedge clk); cmd_op = op;
        for (int i = 0; i < n; i++) begin
            #1; if (cmd_gnt) hits++;
            @(negedge clk);
        end
        cmd_op = NOP;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(8 * 100000);
        fails++;
        $display("FAIL watchdog: got 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int t0, t1, t2, t3, h;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check("R1 rdata", cfg_rdata, 0);
        check("R1 err", cfg_err, 1);
        check("R1 row_open", row_open, 0);
        probe(OPN, 6, h);
        check("R1 R3 no grant after reset", h, 0);

        // R3 wrong key patterns
        write_cfg(16'h0200); #1;
        check("R3 err key 10", cfg_err, 1);
        probe(OPN, 6, h);
        check("R3 key 10 blocks", h, 0);
        write_cfg(16'h0300);
        probe(OPN, 6, h);
        check("R3 key 11 blocks", h, 0);

        // R2 upper bits read zero
        write_cfg(16'hFFFF); #1;
        check("R2 readback masked", cfg_rdata, 16'h03FF);

        // R10 order with a valid word
        write_cfg(16'h0100); #1;
        check("R2 readback", cfg_rdata, 16'h0100);
        probe(CLS, 6, h);
        check("R10 close without row", h, 0);
        probe(ACC, 6, h);
        check("R10 access without row", h, 0);
        probe(NOP, 6, h);
        check("R10 nothing never granted", h, 0);
        issue(OPN, t0);
        check("R10 row_open after open", row_open, 1);
        idle(10);
        probe(OPN, 6, h);
        check("R10 open while open", h, 0);
        issue(CLS, t1);
        check("R10 row closed", row_open, 0);
        idle(10);

        // table walk: R4 R5 R6 R7 R8 R9
        for (int k = 0; k < 6; k++) begin
            write_cfg(TBL[k].cfg); #1;
            check("R2 table readback", cfg_rdata, TBL[k].cfg);
            check("R8 err flag", cfg_err, TBL[k].err);
            issue(OPN, t0);
            issue(ACC, t1);
            check("R7 R9 open to access", t1 - t0, TBL[k].rcd);
            issue(CLS, t2);
            check("R5 R9 open to close", t2 - t0, TBL[k].ras);
            issue(OPN, t3);
            check("R4 R6 R8 open to open", t3 - t0, TBL[k].o2o);
            issue(CLS, t1);
            idle(10);
        end

        // R6 alone: long close-to-open with short other counts
        write_cfg(16'h0108);
        issue(OPN, t0);
        issue(CLS, t1);
        issue(OPN, t2);
        check("R6 close to open 3", t2 - t1, 3);
        issue(CLS, t1);
        idle(10);

        // R11 rewrite mid-interval
        write_cfg(16'h0159);
        issue(OPN, t0);
        write_cfg(16'h0100);
        issue(CLS, t1);
        check("R11 close keeps old length", t1 - t0, 5);
        issue(OPN, t2);
        check("R11 open uses old row cycle", t2 - t0, 7);
        issue(CLS, t1);
        idle(4);

        // R3 clearing the key blocks an otherwise legal open
        write_cfg(16'h0000); #1;
        check("R3 err key 00", cfg_err, 1);
        probe(OPN, 6, h);
        check("R3 key 00 blocks", h, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule